// File: doc/BRIEF.md
# Linear Frequency Sweep Engine

This block produces a 32-bit frequency tuning word and integrates it in a 32-bit phase accumulator whose value is the block's main output. The synthesized frequency is the tuning word over 2^32, times the system clock. A small write port loads the configuration: a mode word, a start word and a stop word, one delta word for each direction and one ramp-rate word for each direction.

With sweeping disabled the block holds the start word as a steady single tone. With sweeping enabled, a rising edge on the profile input starts a linear climb from the start word to the stop word. Frequency steps land on a sync tick that runs at one quarter of the system clock, and a programmable number of ticks separates the steps.

At the top there are two behaviours. In no-dwell mode the word snaps back to the start word and waits for the next profile edge. In dwell mode the word holds at the stop word while the profile stays high, then falls back to the start word once the profile drops.

Top module: `chirp_synth`

## Requirements
- R1: While synchronous reset is applied the tuning word and the phase output are both 0, and all configuration words are 0.
- R2: On every clock out of reset, the phase output advances by the tuning word that was present in the previous cycle, modulo 2^32.
- R3: Unless mode bits [23:22] hold the value 2 and mode bit [14] is 1, the tuning word equals the start word, and the profile input has no effect on it.
- R4: With sweeping enabled, a 0-to-1 transition on the profile input starts a rising sweep from the start word. Each rising step adds the rising delta word to the tuning word.
- R5: Rising steps are spaced 4 x riseRate clocks apart, because the sync tick occurs once every 4 system clocks.
- R6: A rising step that would reach or pass the stop word sets the tuning word exactly to the stop word, and that step ends the rising sweep.
- R7: With mode bit [15] (no-dwell) set, the tuning word returns to the start word one clock after it reaches the stop word. A profile input that stays high does not start another sweep; only a new 0-to-1 edge does.
- R8: With mode bit [15] clear, the tuning word holds at the stop word for as long as the profile input stays high.
- R9: In dwell mode, dropping the profile input after the top starts a falling sweep. Each falling step subtracts the falling delta word, and steps are spaced 4 x fallRate clocks apart. A step that would reach or pass the start word sets the tuning word to the start word, where it then holds.
- R10: A ramp-rate word of 0 behaves exactly like a ramp-rate word of 1, giving one step per sync tick.
- R11: Register writes use these addresses: 0 = mode, 1 = start word, 2 = stop word, 3 = rising delta, 4 = falling delta, 5 = rising ramp rate (low 16 bits), 6 = falling ramp rate (low 16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| profile | input | 1 | Sweep trigger and dwell control |
| tuneWord | output | 32 | Current frequency tuning word |
| phase | output | 32 | Phase accumulator value |

## Verification
If the step counter or the sweep state is wrong, the tuning word changes at the wrong spacing or heads to the wrong value. The first step after the fault already exposes it, so every word change is checked both for its value and for its distance from the previous change. A stale tuning word or a wrong limit comparison appears as a missing or extra clamp step within one step interval. A faulty accumulator shows up in the phase output on the very next clock.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  // Mode word field positions; the sweep decode depends on these
  localparam int FUNC_LO      = 22;
  localparam int LIN_BIT      = 14;
  localparam int NODWELL_BIT  = 15;
  localparam logic [1:0] SWEEP_FUNC = 2'd2;

  // Register addresses
  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_START = 3'd1;
  localparam logic [2:0] A_STOP  = 3'd2;
  localparam logic [2:0] A_RDLT  = 3'd3;
  localparam logic [2:0] A_FDLT  = 3'd4;
  localparam logic [2:0] A_RRATE = 3'd5;
  localparam logic [2:0] A_FRATE = 3'd6;

  typedef struct packed {
    logic loadStart;
    logic stepUp;
    logic stepDown;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_TOP  = 2'd2,
    ST_FALL = 2'd3
  } sweep_state_e;

endpackage

// File: rtl/chirp_cfg.sv
module chirp_cfg
  import chirp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sweepOn,
  output logic              noDwell,
  output logic [DATA_W-1:0] startW,
  output logic [DATA_W-1:0] stopW,
  output logic [DATA_W-1:0] riseDelta,
  output logic [DATA_W-1:0] fallDelta,
  output logic [RATE_W-1:0] riseRate,
  output logic [RATE_W-1:0] fallRate
);

  logic [1:0] funcField;
  logic       linEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      funcField <= '0;
      linEn     <= 1'b0;
      noDwell   <= 1'b0;
      startW    <= '0;
      stopW     <= '0;
      riseDelta <= '0;
      fallDelta <= '0;
      riseRate  <= '0;
      fallRate  <= '0;
    end else if (we) begin
      case (addr)
        A_MODE: begin
          funcField <= wdata[FUNC_LO+1:FUNC_LO];
          linEn     <= wdata[LIN_BIT];
          noDwell   <= wdata[NODWELL_BIT];
        end
        A_START: startW    <= wdata;
        A_STOP:  stopW     <= wdata;
        A_RDLT:  riseDelta <= wdata;
        A_FDLT:  fallDelta <= wdata;
        A_RRATE: riseRate  <= wdata[RATE_W-1:0];
        A_FRATE: fallRate  <= wdata[RATE_W-1:0];
        default: ;
      endcase
    end
  end

  assign sweepOn = (funcField == SWEEP_FUNC) && linEn;

endmodule

// File: rtl/chirp_ctrl.sv
module chirp_ctrl
  import chirp_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int SYNC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sweepOn,
  input  logic              noDwell,
  input  logic              profile,
  input  logic [RATE_W-1:0] riseRate,
  input  logic [RATE_W-1:0] fallRate,
  input  logic              upReach,
  input  logic              downReach,
  output strobe_t           str
);

  localparam int PRE_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SYNC_DIV - 1);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  sweep_state_e     state;
  logic [PRE_W-1:0] pre;
  logic [RATE_W-1:0] cnt;
  logic             profPrev;
  logic             tick;
  logic             profRise;
  logic             cntDone;
  logic [RATE_W-1:0] riseEff;
  logic [RATE_W-1:0] fallEff;

  assign tick     = (pre == PRE_LAST);
  assign profRise = profile && !profPrev;
  assign cntDone  = (cnt == ONE);
  assign riseEff  = (riseRate == '0) ? ONE : riseRate;
  assign fallEff  = (fallRate == '0) ? ONE : fallRate;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pre      <= '0;
      cnt      <= ONE;
      profPrev <= 1'b0;
    end else begin
      pre      <= tick ? '0 : pre + 1'b1;
      profPrev <= profile;
      case (state)
        ST_IDLE: begin
          if (sweepOn && profRise) begin
            state <= ST_RISE;
            cnt   <= riseEff;
          end
        end
        ST_RISE: begin
          if (!sweepOn) state <= ST_IDLE;
          else if (tick) begin
            if (cntDone) begin
              cnt <= riseEff;
              if (upReach) state <= noDwell ? ST_IDLE : ST_TOP;
            end else cnt <= cnt - 1'b1;
          end
        end
        ST_TOP: begin
          if (!sweepOn) state <= ST_IDLE;
          else if (!profile) begin
            state <= ST_FALL;
            cnt   <= fallEff;
          end
        end
        ST_FALL: begin
          if (!sweepOn) state <= ST_IDLE;
          else if (tick) begin
            if (cntDone) begin
              cnt <= fallEff;
              if (downReach) state <= ST_IDLE;
            end else cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str.loadStart = (state == ST_IDLE);
    str.stepUp    = (state == ST_RISE) && sweepOn && tick && cntDone;
    str.stepDown  = (state == ST_FALL) && sweepOn && tick && cntDone;
  end

  // R3
  sweep_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sweepOn |=> state == ST_IDLE);

  // R10
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

  // R8
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TOP && profile && sweepOn) |=> state == ST_TOP);

endmodule

// File: rtl/chirp_dp.sv
module chirp_dp
  import chirp_pkg::*;
#(
  parameter int TW_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  strobe_t         str,
  input  logic [TW_W-1:0] startW,
  input  logic [TW_W-1:0] stopW,
  input  logic [TW_W-1:0] riseDelta,
  input  logic [TW_W-1:0] fallDelta,
  output logic [TW_W-1:0] word,
  output logic [TW_W-1:0] phase,
  output logic            upReach,
  output logic            downReach
);

  logic [TW_W:0]   upSum;
  logic [TW_W-1:0] downDiff;
  logic            chkArmed;

  assign upSum     = {1'b0, word} + {1'b0, riseDelta};
  assign downDiff  = word - fallDelta;
  assign upReach   = upSum[TW_W] || (upSum[TW_W-1:0] >= stopW);
  assign downReach = (word < fallDelta) || (downDiff <= startW);

  always_ff @(posedge clk) begin
    if (rst) begin
      word     <= '0;
      phase    <= '0;
      chkArmed <= 1'b0;
    end else begin
      phase    <= phase + word;
      chkArmed <= 1'b1;
      if (str.loadStart)     word <= startW;
      else if (str.stepUp)   word <= upReach ? stopW : upSum[TW_W-1:0];
      else if (str.stepDown) word <= downReach ? startW : downDiff;
    end
  end

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    chkArmed |-> phase == $past(phase) + $past(word));

  // R3
  idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    str.loadStart |=> word == $past(startW));

  // R6
  rise_bound_chk: assert property (@(posedge clk) disable iff (rst)
    str.stepUp |=> (word == $past(stopW)) || (word > $past(word)));

endmodule

// File: rtl/chirp_synth.sv
module chirp_synth
  import chirp_pkg::*;
#(
  parameter int TW_W     = 32,
  parameter int RATE_W   = 16,
  parameter int SYNC_DIV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWe,
  input  logic [2:0]      cfgAddr,
  input  logic [TW_W-1:0] cfgData,
  input  logic            profile,
  output logic [TW_W-1:0] tuneWord,
  output logic [TW_W-1:0] phase
);

  logic              sweepOn, noDwell, upReach, downReach;
  logic [TW_W-1:0]   startW, stopW, riseDelta, fallDelta;
  logic [RATE_W-1:0] riseRate, fallRate;
  strobe_t           str;

  chirp_cfg #(.DATA_W(TW_W), .RATE_W(RATE_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfgWe), .addr(cfgAddr), .wdata(cfgData),
    .sweepOn(sweepOn), .noDwell(noDwell), .startW(startW), .stopW(stopW),
    .riseDelta(riseDelta), .fallDelta(fallDelta),
    .riseRate(riseRate), .fallRate(fallRate)
  );

  chirp_ctrl #(.RATE_W(RATE_W), .SYNC_DIV(SYNC_DIV)) ctrl_i (
    .clk(clk), .rst(rst), .sweepOn(sweepOn), .noDwell(noDwell),
    .profile(profile), .riseRate(riseRate), .fallRate(fallRate),
    .upReach(upReach), .downReach(downReach), .str(str)
  );

  chirp_dp #(.TW_W(TW_W)) dp_i (
    .clk(clk), .rst(rst), .str(str), .startW(startW), .stopW(stopW),
    .riseDelta(riseDelta), .fallDelta(fallDelta), .word(tuneWord),
    .phase(phase), .upReach(upReach), .downReach(downReach)
  );

endmodule

// File: tb/chirp_synth_tb.sv
module chirp_synth_tb_top;

  typedef struct {
    logic [31:0] w;
    int          gap;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        profile = 1'b0;
  logic [31:0] tuneWord, phase;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastT = 0;
  int phaseErr = 0;
  bit monActive = 1'b0;
  bit phaseArm = 1'b0;
  logic [31:0] lastWord, prevPhase, prevWord;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;  // 50 MHz

  chirp_synth dut_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .profile(profile), .tuneWord(tuneWord), .phase(phase)
  );

  localparam logic [31:0] M_SWEEP = (32'd2 << 22) | (32'd1 << 14);
  localparam logic [31:0] M_ND    = 32'd1 << 15;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic push(input logic [31:0] w, input int gap, input string req);
    exp_t x;
    x.w = w; x.gap = gap; x.req = req;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic monOff();
    @(negedge clk);
    monActive = 1'b0;
  endtask

  task automatic monOn();
    idle(3);
    monActive = 1'b1;
    idle(1);
  endtask

  // Monitor: pops expected words as the design changes its tuning word
  always @(negedge clk) begin
    cyc++;
    if (rst || !monActive) begin
      lastWord = tuneWord;
      lastT = cyc;
    end else if (tuneWord !== lastWord) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected change actual=%0d expected=%0d", tuneWord, lastWord);
      end else begin
        e = q.pop_front();
        if (tuneWord !== e.w || (e.gap != 0 && (cyc - lastT) != e.gap)) begin
          fails++;
          $display("FAIL %s actual=%0d gap=%0d expected=%0d gap=%0d",
                   e.req, tuneWord, cyc - lastT, e.w, e.gap);
        end
      end
      lastWord = tuneWord;
      lastT = cyc;
    end
    if (!rst && phaseArm && phase !== prevPhase + prevWord) phaseErr++;
    prevPhase = phase;
    prevWord = tuneWord;
    phaseArm = !rst;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 word", tuneWord, 32'd0);
    check("R1 phase", phase, 32'd0);
    rst = 1'b0;
    idle(2);
    check("R1 phase stays 0", phase, 32'd0);

    // R11 / R3 single tone, mode 0
    wr(3'd1, 32'd1000);
    wr(3'd2, 32'd2000);
    wr(3'd3, 32'd300);
    wr(3'd5, 32'd2);
    wr(3'd0, 32'd0);
    monOn();
    check("R11 start word at addr 1", tuneWord, 32'd1000);
    profile = 1'b1; idle(40); profile = 1'b0; idle(10);
    check("R3 mode 0 ignores profile", tuneWord, 32'd1000);
    // R3 function field 2 without linear enable
    monOff(); wr(3'd0, 32'd2 << 22); monOn();
    profile = 1'b1; idle(40); profile = 1'b0; idle(10);
    check("R3 linear bit clear ignores profile", tuneWord, 32'd1000);

    // R4 R5 R6 R7 no-dwell up-chirp, rate 2
    monOff(); wr(3'd0, M_SWEEP | M_ND); monOn();
    push(32'd1300, 0, "R4 first rise step");
    push(32'd1600, 8, "R5 rise step spacing");
    push(32'd1900, 8, "R5 rise step spacing");
    push(32'd2000, 8, "R6 clamp at stop");
    push(32'd1000, 1, "R7 return to start");
    profile = 1'b1;
    idle(60);
    check("R7 sweep complete", q.size(), 0);
    idle(40);
    check("R7 no retrigger while high", tuneWord, 32'd1000);
    profile = 1'b0; idle(4);

    // R10 rate 0 acts as 1, exact hit of stop
    monOff(); wr(3'd3, 32'd250); wr(3'd5, 32'd0); monOn();
    push(32'd1250, 0, "R10 first step");
    push(32'd1500, 4, "R10 rate0 spacing");
    push(32'd1750, 4, "R10 rate0 spacing");
    push(32'd2000, 4, "R6 exact stop");
    push(32'd1000, 1, "R7 return to start");
    profile = 1'b1;
    idle(40);
    check("R10 sweep complete", q.size(), 0);
    profile = 1'b0; idle(4);

    // R8 R9 dwell triangle
    monOff();
    wr(3'd0, M_SWEEP);
    wr(3'd3, 32'd500);
    wr(3'd5, 32'd1);
    wr(3'd4, 32'd400);
    wr(3'd6, 32'd3);
    monOn();
    push(32'd1500, 0, "R4 dwell first step");
    push(32'd2000, 4, "R6 dwell reach stop");
    profile = 1'b1;
    idle(30);
    check("R8 rise complete", q.size(), 0);
    idle(40);
    check("R8 hold at stop", tuneWord, 32'd2000);
    push(32'd1600, 0, "R9 first fall step");
    push(32'd1200, 12, "R9 fall spacing");
    push(32'd1000, 12, "R9 clamp at start");
    profile = 1'b0;
    idle(60);
    check("R9 fall complete", q.size(), 0);
    check("R9 holds start", tuneWord, 32'd1000);

    // R2 phase accumulation over the whole run
    check("R2 phase errors", phaseErr, 0);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule